// File: doc/BRIEF.md
# Nibble-Paired Parallel Host Interface

This block sits between a host processor and the core of a display controller. The host reaches it over a four-line data path with separate active-low read and write strobes, an active-low select and a register-select line. Every byte crosses that path as two transfers, upper nibble first. The block pairs the nibbles back into bytes. It sends each written byte to the core with a flag that marks it as an instruction or as data. It serves host reads of display RAM from a one-byte prefetch buffer that the core fills.

The strobe and select inputs are sampled on the system clock through a short register pipeline. A nibble counts as transferred on the trailing (rising) edge of its strobe. A phase bit records which half of the byte the next strobe carries. A RAM read returns the byte fetched by the previous read pair. For this reason the host must first issue one dummy read pair after any write. The dummy pair returns zeros. Each completed data read pair consumes the buffer and starts the next fetch.

The write port is valid/ready. `wr_valid` stays high, with data and flag held, until the core raises `wr_ready`. The slot holds one byte. A byte that completes while the slot is still full and not being taken in that cycle is discarded. The fetch request (`rreq_valid`/`rreq_ready`) stays asserted until it is accepted. The response port raises `rrsp_ready` only while a fetch is outstanding. The core keeps its own RAM address, so a request carries no address.

Top module: `nib_host_if`

## Requirements
- R1: After reset, `wr_valid`, `rreq_valid`, `db_oe` and `db_out` are all zero, the phase is upper, and the prefetch buffer is empty.
- R2: Two completed write strobes form one byte: the first nibble becomes bits 7..4 and the second bits 3..0. `wr_is_data` equals the register-select value at the first strobe (1 = data register, 0 = instruction register).
- R3: A write nibble is taken from the value on `db_in` while the write strobe is low, as seen at its rising edge. Values driven before the strobe falls or after it rises have no effect.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_is_data` hold. A byte that completes while the slot is full and not being accepted is discarded.
- R5: The phase flips on every completed strobe, read or write, while selected. Deasserting `cs_n` returns it to upper, so a half-finished pair is abandoned.
- R6: `db_oe` is high only while both `cs_n` and `rd_n` are low. While `db_oe` is low, `db_out` is zero. The upper nibble is driven in the upper phase and the lower nibble in the lower phase.
- R7: A data read pair (register select 1) made while the prefetch buffer is empty returns zero on both nibbles. At the trailing edge of its second strobe it raises one fetch request.
- R8: A data read pair made while the buffer is full returns the buffered byte. It then empties the buffer and raises the next fetch request.
- R9: Every completed write byte, instruction or data, empties the prefetch buffer. A fetch response for a request outstanding at that write is accepted and dropped.
- R10: An instruction read pair (register select 0) returns zero, raises no fetch, and leaves the prefetch buffer unchanged.
- R11: `rreq_valid` stays high until `rreq_ready`. `rrsp_ready` is high only while an accepted fetch awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low host select |
| rs | input | 1 | Register select: 1 data, 0 instruction |
| wr_n | input | 1 | Active-low host write strobe |
| rd_n | input | 1 | Active-low host read strobe |
| db_in | input | NIB_W | Nibble driven by the host |
| db_out | output | NIB_W | Nibble returned to the host |
| db_oe | output | 1 | Enable for the returned nibble |
| wr_valid | output | 1 | Assembled byte is available |
| wr_ready | input | 1 | Core takes the byte |
| wr_data | output | 2*NIB_W | Assembled byte |
| wr_is_data | output | 1 | 1 for a data byte, 0 for an instruction |
| rreq_valid | output | 1 | Fetch request to the core |
| rreq_ready | input | 1 | Core accepts the fetch |
| rrsp_valid | input | 1 | Core returns fetched byte |
| rrsp_ready | output | 1 | Block takes the fetched byte |
| rrsp_data | input | 2*NIB_W | Fetched byte |

## Verification
The bound checker checks on every clock the rules that hold at any moment: the output enable never rises without select and read strobe, and the released data lines read zero. It also checks that write and fetch outputs hold under back-pressure, that the response side is ready only while no request is waiting, and that a deselected bus leaves the phase at upper. The bench's scenarios cover the rules that depend on ordering. These are nibble pairing and capture timing, the dummy-read sequence, fetched bytes coming back in address order, invalidation by writes, and a late response that is dropped. The bench checks these against its own model of the core's RAM and address counter.

// File: rtl/nhi_pkg.sv
package nhi_pkg;

  typedef enum logic {
    PH_UPPER = 1'b0,
    PH_LOWER = 1'b1
  } nib_phase_e;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
  } strobe_ctl_t;

  localparam strobe_ctl_t CTL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};

endpackage

// File: rtl/nhi_strobe_sync.sv
// Samples the host bus into the clock domain and flags trailing strobe edges.
// STAGES must be at least 2: the last two stages form the edge detector.
module nhi_strobe_sync
  import nhi_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rs,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [NIB_W-1:0] db_in,
  output logic             cs_idle,
  output logic             wr_end,
  output logic             rd_end,
  output logic [NIB_W-1:0] evt_nib,
  output logic             evt_rs
);

  localparam int BUS_W  = NIB_W + 1;
  localparam int BUS_ST = STAGES - 1;

  strobe_ctl_t ctl_q [STAGES];
  strobe_ctl_t ctl_now, cur, prv;
  logic [BUS_W-1:0] bus_q [BUS_ST];
  logic [BUS_W-1:0] bus_cur;
  logic [BUS_W-1:0] hold_q;

  assign ctl_now = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) ctl_q[i] <= CTL_IDLE;
    end else begin
      ctl_q[0] <= ctl_now;
      for (int i = 1; i < STAGES; i++) ctl_q[i] <= ctl_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUS_ST; i++) bus_q[i] <= '0;
    end else begin
      bus_q[0] <= {rs, db_in};
      for (int i = 1; i < BUS_ST; i++) bus_q[i] <= bus_q[i-1];
    end
  end

  assign cur     = ctl_q[STAGES-2];
  assign prv     = ctl_q[STAGES-1];
  assign bus_cur = bus_q[BUS_ST-1];

  // Latest bus value seen while a strobe is low; frozen once it rises.
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (!cur.cs_n && (!cur.wr_n || !cur.rd_n)) hold_q <= bus_cur;
  end

  assign wr_end  = !prv.cs_n && !prv.wr_n && cur.wr_n;
  assign rd_end  = !prv.cs_n && !prv.rd_n && cur.rd_n;
  assign cs_idle = cur.cs_n;
  assign evt_nib = hold_q[NIB_W-1:0];
  assign evt_rs  = hold_q[NIB_W];

endmodule

// File: rtl/nhi_pairer.sv
// Tracks the nibble phase, assembles write bytes and owns the write slot.
module nhi_pairer
  import nhi_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_idle,
  input  logic               wr_end,
  input  logic               rd_end,
  input  logic [NIB_W-1:0]   evt_nib,
  input  logic               evt_rs,
  input  logic               wr_ready,
  output logic               phase_lo,
  output logic               rs_hold,
  output logic               wr_valid,
  output logic [2*NIB_W-1:0] wr_data,
  output logic               wr_is_data,
  output logic               byte_written,
  output logic               rd_pair_done
);

  nib_phase_e       phase_q;
  logic [NIB_W-1:0] up_nib_q;
  logic             rs_q;
  logic             any_end, slot_free;

  assign any_end      = wr_end || rd_end;
  assign byte_written = wr_end && (phase_q == PH_LOWER);
  assign rd_pair_done = rd_end && (phase_q == PH_LOWER);
  assign slot_free    = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_UPPER;
    end else if (cs_idle) begin
      phase_q <= PH_UPPER;
    end else if (any_end) begin
      phase_q <= (phase_q == PH_UPPER) ? PH_LOWER : PH_UPPER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_nib_q <= '0;
      rs_q     <= 1'b0;
    end else if (any_end && phase_q == PH_UPPER) begin
      up_nib_q <= evt_nib;
      rs_q     <= evt_rs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_is_data <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (byte_written && slot_free) begin
        wr_valid   <= 1'b1;
        wr_data    <= {up_nib_q, evt_nib};
        wr_is_data <= rs_q;
      end
    end
  end

  assign phase_lo = (phase_q == PH_LOWER);
  assign rs_hold  = rs_q;

endmodule

// File: rtl/nhi_prefetch.sv
// One-byte read-ahead buffer with fetch request and stale-response discard.
module nhi_prefetch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_written,
  input  logic              fetch_go,
  output logic              rreq_valid,
  input  logic              rreq_ready,
  input  logic              rrsp_valid,
  output logic              rrsp_ready,
  input  logic [BYTE_W-1:0] rrsp_data,
  output logic              pf_valid,
  output logic [BYTE_W-1:0] pf_data
);

  logic pend_q, stale_q;
  logic req_fire, rsp_fire;

  assign req_fire   = rreq_valid && rreq_ready;
  assign rsp_fire   = rrsp_valid && rrsp_ready;
  assign rrsp_ready = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rreq_valid <= 1'b0;
      pend_q     <= 1'b0;
      stale_q    <= 1'b0;
      pf_valid   <= 1'b0;
      pf_data    <= '0;
    end else begin
      if (fetch_go) begin
        pf_valid   <= 1'b0;
        rreq_valid <= 1'b1;
      end
      if (req_fire) begin
        rreq_valid <= 1'b0;
        pend_q     <= 1'b1;
      end
      if (rsp_fire) begin
        pend_q  <= 1'b0;
        stale_q <= 1'b0;
        if (!stale_q) begin
          pf_valid <= 1'b1;
          pf_data  <= rrsp_data;
        end
      end
      if (byte_written) begin
        pf_valid <= 1'b0;
        if (rreq_valid || (pend_q && !rsp_fire)) stale_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nib_host_if.sv
module nib_host_if #(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rs,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic [NIB_W-1:0]   db_in,
  output logic [NIB_W-1:0]   db_out,
  output logic               db_oe,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [2*NIB_W-1:0] wr_data,
  output logic               wr_is_data,
  output logic               rreq_valid,
  input  logic               rreq_ready,
  input  logic               rrsp_valid,
  output logic               rrsp_ready,
  input  logic [2*NIB_W-1:0] rrsp_data
);

  localparam int BYTE_W = 2 * NIB_W;

  logic             cs_idle, wr_end, rd_end, evt_rs;
  logic [NIB_W-1:0] evt_nib;
  logic             phase_lo, rs_hold, byte_written, rd_pair_done;
  logic             pf_valid;
  logic [BYTE_W-1:0] pf_data;
  logic             sel_rs;
  logic [NIB_W-1:0] pf_nib;

  nhi_strobe_sync #(.NIB_W(NIB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .rd_n(rd_n),
    .db_in(db_in), .cs_idle(cs_idle), .wr_end(wr_end), .rd_end(rd_end),
    .evt_nib(evt_nib), .evt_rs(evt_rs)
  );

  nhi_pairer #(.NIB_W(NIB_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .wr_end(wr_end), .rd_end(rd_end),
    .evt_nib(evt_nib), .evt_rs(evt_rs), .wr_ready(wr_ready), .phase_lo(phase_lo),
    .rs_hold(rs_hold), .wr_valid(wr_valid), .wr_data(wr_data), .wr_is_data(wr_is_data),
    .byte_written(byte_written), .rd_pair_done(rd_pair_done)
  );

  nhi_prefetch #(.BYTE_W(BYTE_W)) u_pf (
    .clk(clk), .rst_n(rst_n), .byte_written(byte_written),
    .fetch_go(rd_pair_done && rs_hold), .rreq_valid(rreq_valid),
    .rreq_ready(rreq_ready), .rrsp_valid(rrsp_valid), .rrsp_ready(rrsp_ready),
    .rrsp_data(rrsp_data), .pf_valid(pf_valid), .pf_data(pf_data)
  );

  // Return path: register select comes live in the upper phase, held in the lower.
  assign db_oe  = !cs_n && !rd_n;
  assign sel_rs = phase_lo ? rs_hold : rs;
  assign pf_nib = phase_lo ? pf_data[NIB_W-1:0] : pf_data[BYTE_W-1:NIB_W];
  assign db_out = (db_oe && sel_rs && pf_valid) ? pf_nib : '0;

endmodule

// File: rtl/nhi_chk.sv
module nhi_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               rd_n,
  input logic               db_oe,
  input logic [NIB_W-1:0]   db_out,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [2*NIB_W-1:0] wr_data,
  input logic               wr_is_data,
  input logic               rreq_valid,
  input logic               rreq_ready,
  input logic               rrsp_ready,
  input logic               phase_lo
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wr_valid && !rreq_valid && !phase_lo);

  p_oe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !db_oe);

  p_oe_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !db_oe);

  p_released_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !db_oe |-> db_out == '0);

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_is_data));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_valid && !rreq_ready |=> rreq_valid);

  p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rrsp_ready |-> !rreq_valid);

  p_phase_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |=> !phase_lo);

endmodule

bind nib_host_if nhi_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .db_oe(db_oe), .db_out(db_out),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_is_data(wr_is_data),
  .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rrsp_ready(rrsp_ready),
  .phase_lo(phase_lo)
);

// File: tb/test_nib_host_if.sv
`timescale 1ns/1ps
module test_nib_host_if;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [3:0] db_in = 4'h0;
  logic [3:0] db_out;
  logic db_oe, wr_valid, wr_is_data, rreq_valid, rrsp_ready;
  logic wr_ready = 1'b1, rreq_ready = 1'b1, rrsp_valid = 1'b0;
  logic [7:0] wr_data, rrsp_data = 8'h00;

  int checks = 0, errors = 0, fetches = 0, core_lat = 2;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nib_host_if i_nib_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .rd_n(rd_n),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_is_data(wr_is_data),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rrsp_valid(rrsp_valid),
    .rrsp_ready(rrsp_ready), .rrsp_data(rrsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Core model: RAM with an address counter, fed by the write and fetch ports.
  logic [7:0] mem [128];
  int addr = 0, cnt = 0;
  logic [7:0] pend_byte;
  logic [8:0] exp_q [$];

  always @(posedge clk) begin
    if (rst_n) begin
      chk(db_oe == (!cs_n && !rd_n), "R6 oe", db_oe, !cs_n && !rd_n);
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", {wr_is_data, wr_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({wr_is_data, wr_data} == e, "R2 byte", {wr_is_data, wr_data}, e);
        end
        if (wr_is_data) begin mem[addr] = wr_data; addr = (addr + 1) % 128; end
        else if (wr_data[7]) addr = int'(wr_data[6:0]);
      end
      if (rrsp_valid && rrsp_ready) rrsp_valid <= 1'b0;
      if (rreq_valid && rreq_ready) begin
        fetches++;
        pend_byte = mem[addr];
        addr = (addr + 1) % 128;
        cnt = core_lat;
      end else if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin rrsp_valid <= 1'b1; rrsp_data <= pend_byte; end
      end
    end
  end

  task automatic wr_nib(input logic rsv, input logic [3:0] n);
    @(negedge clk); cs_n = 1'b0; rs = rsv; db_in = ~n;
    @(negedge clk); wr_n = 1'b0; db_in = n;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; db_in = n ^ 4'h5; rs = ~rsv;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_byte(input logic rsv, input logic [7:0] b, input bit expect_it);
    if (expect_it) exp_q.push_back({rsv, b});
    wr_nib(rsv, b[7:4]);
    wr_nib(rsv, b[3:0]);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_nib(input logic rsv, output logic [3:0] got);
    @(negedge clk); cs_n = 1'b0; rs = rsv; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    got = db_out;
    chk(db_oe === 1'b1, "R6 oe during read", db_oe, 1);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_byte(input logic rsv, output logic [7:0] b);
    logic [3:0] h, l;
    rd_nib(rsv, h);
    rd_nib(rsv, l);
    b = {h, l};
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int f0;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 29 + 7);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!wr_valid, "R1 wr_valid", wr_valid, 0);
    chk(!rreq_valid, "R1 rreq_valid", rreq_valid, 0);
    chk(!db_oe && db_out == 0, "R1 read path idle", db_out, 0);
    chk(!rrsp_ready, "R1 rrsp_ready", rrsp_ready, 0);

    // R2, R3: pairing, flag and capture window
    write_byte(1'b0, 8'h80, 1'b1);
    write_byte(1'b1, 8'hA6, 1'b1);
    write_byte(1'b1, 8'h3F, 1'b1);
    chk(mem[0] == 8'hA6 && mem[1] == 8'h3F, "R3 captured nibbles", {mem[0], mem[1]}, 16'hA63F);

    // R4: back-pressure holds the first byte, the second is discarded
    wr_ready = 1'b0;
    write_byte(1'b1, 8'h5A, 1'b1);
    write_byte(1'b1, 8'hC3, 1'b0);
    chk(wr_valid && wr_data == 8'h5A && wr_is_data, "R4 held byte", wr_data, 8'h5A);
    wr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid, "R4 slot drained", wr_valid, 0);

    // R5: deselect abandons a half pair
    wr_nib(1'b1, 4'hE);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(1'b1, 8'h71, 1'b1);
    chk(mem[3] == 8'h71, "R5 fresh pair after deselect", mem[3], 8'h71);

    // R7: dummy read
    write_byte(1'b0, 8'h85, 1'b1);
    f0 = fetches;
    rd_byte(1'b1, b);
    chk(b == 8'h00, "R7 dummy returns zero", b, 0);
    chk(fetches == f0 + 1, "R7 one fetch", fetches, f0 + 1);

    // R8: sequential reads
    rd_byte(1'b1, b);
    chk(b == mem[5], "R8 first byte", b, mem[5]);
    rd_byte(1'b1, b);
    chk(b == mem[6], "R8 second byte", b, mem[6]);
    chk(fetches == f0 + 3, "R8 fetch per pair", fetches, f0 + 3);

    // R11: fetch request held under back-pressure
    rreq_ready = 1'b0;
    rd_byte(1'b1, b);
    chk(b == mem[7], "R8 third byte", b, mem[7]);
    chk(rreq_valid, "R11 request held", rreq_valid, 1);
    chk(!rrsp_ready, "R11 no response wait before accept", rrsp_ready, 0);
    rreq_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(!rreq_valid, "R11 request released", rreq_valid, 0);
    rd_byte(1'b1, b);
    chk(b == mem[8], "R11 late fetch data", b, mem[8]);

    // R10: instruction read leaves the buffer alone
    f0 = fetches;
    rd_byte(1'b0, b);
    chk(b == 8'h00, "R10 instruction read zero", b, 0);
    chk(fetches == f0, "R10 no fetch", fetches, f0);
    rd_byte(1'b1, b);
    chk(b == mem[9], "R10 buffer intact", b, mem[9]);

    // R9: a write empties the buffer
    write_byte(1'b1, 8'h3C, 1'b1);
    rd_byte(1'b1, b);
    chk(b == 8'h00, "R9 read after write is dummy", b, 0);
    rd_byte(1'b1, b);
    chk(b == mem[12], "R9 data after dummy", b, mem[12]);

    // R9: response for a fetch outstanding at a write is dropped
    core_lat = 40;
    write_byte(1'b0, 8'h90, 1'b1);
    rd_byte(1'b1, b);
    write_byte(1'b0, 8'h94, 1'b1);
    repeat (60) @(negedge clk);
    core_lat = 2;
    rd_byte(1'b1, b);
    chk(b == 8'h00, "R9 stale response dropped", b, 0);
    rd_byte(1'b1, b);
    chk(b == mem[20], "R9 data at new address", b, mem[20]);

    // R6: no drive without select
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!db_oe && db_out == 0, "R6 released without select", db_oe, 0);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule